// File: doc/BRIEF.md
# MDIO Management Target with Extended Register Addressing

This block is the target side of a two-wire management serial link. It runs on the management clock and watches a shared, pulled-up data line. It waits for a long run of ones and a start pattern. It then decodes a read or write opcode, a 5-bit device address and a 5-bit register address, all sent MSB first. On a read it takes the line for the second turnaround bit and for 16 data bits. On a write it shifts in 16 data bits and hands the word to a register file through a simple strobe port. The register file itself sits outside the block.

There are two ways to reach registers. In standard mode, each device address in a configured window selects one port, and each port exposes eight 16-bit registers. In extended mode, the middle two device-address bits are both set. The remaining three device-address bits are then joined to the register address to index a flat space of 256 byte-wide registers.

The target samples the line on the rising clock edge and drives it on the falling edge. The timing therefore has half a bit period of margin at management clock rates up to 10 MHz.

Top module: `mdio_mgmt_target`

## Requirements
- R1: A frame is decoded only if at least 32 consecutive sampled ones are followed by the start pattern 0 then 1. With 31 ones, or with a start of 0 then 0, the target gives no strobe and never enables its driver.
- R2: An opcode of 1 then 0 is a read and 0 then 1 is a write. The opcodes 00 and 11 end the frame with no strobe and no drive.
- R3: On a targeted read, the output enable is low during the first turnaround bit. It is high from the second turnaround bit, which is driven as 0, through the 16th data bit. The data goes out MSB first. The enable is low again on the bit after the last data bit, so it is high for exactly 17 bit times.
- R4: A device address with bits [2:1] = 11 selects extended mode (acc_ext = 1) for every value of the other bits. The byte index is {dev[4:3], dev[0], reg[4:0]}, with dev[4] as index bit 7 and reg[0] as index bit 0.
- R5: An extended read returns 8'h00 in the upper data byte and the lower byte of acc_rdata in the lower data byte. The upper byte of acc_rdata is discarded.
- R6: On an extended write, acc_wdata[15:8] is presented as zero, so the upper 8 received bits have no effect.
- R7: In standard mode, device addresses PHY_BASE to PHY_BASE+NUM_PORTS-1 select port (address - PHY_BASE). Any other non-extended address gets no drive and no strobe.
- R8: In standard mode, only register addresses 0 to 5, 29 and 31 are live. A write to any other address gives no strobe and changes nothing. A read of any other address is answered with 16'h0000 and no read strobe.
- R9: A write strobe lasts one cycle and starts on the cycle after the 16th data bit is sampled. A write frame cut short by reset gives no strobe.
- R10: A read strobe lasts one cycle and starts on the cycle after the last register-address bit is sampled. acc_rdata is captured on the next rising edge.
- R11: After an aborted frame, the target decodes again only after a fresh run of 32 ones that begins after the abort. 30 ones after an opcode abort followed by a start are ignored.
- R12: While reset is held, acc_rd, acc_wr and mdio_oe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; data sampled on the rising edge, driven on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| mdio_i | input | 1 | Sampled level of the shared data line |
| mdio_o | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | Output enable for the data line pad |
| acc_rd | output | 1 | One-cycle register read strobe |
| acc_wr | output | 1 | One-cycle register write strobe |
| acc_ext | output | 1 | Access targets the extended byte space |
| acc_port | output | PORT_W | Selected port in standard mode |
| acc_index | output | 8 | Register index (byte index in extended mode, register address in bits [4:0] otherwise) |
| acc_wdata | output | 16 | Write word |
| acc_rdata | input | 16 | Read word from the register file, valid in the cycle after acc_rd |

## Verification
Read strobes are due one cycle after the last register-address bit is sampled. The driven turnaround zero appears on the falling edge one and a half bit times after that sample. Each data bit leads the rising edge at which the master samples it by half a period. The write strobe is due on the cycle after the 16th data bit.

The bench drives and samples every bit 1 ns after a falling edge, which is the point where the target's drive has settled and before the next rising sample. It counts strobes on rising edges and compares the counts only after two trailing idle bits, so a late strobe is still seen within the frame that caused it. Read data and enable counts are compared against values the bench derives from the address rules over every device address, a spread of register addresses and all 256 extended indices.

// File: rtl/mdio_tgt_pkg.sv
`timescale 1ns/1ps
package mdio_tgt_pkg;

    localparam int PRE_LEN = 32;
    localparam int FIELD_W = 5;
    localparam int DATA_W  = 16;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = $clog2(DATA_W);

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        PH_HUNT,
        PH_SOF,
        PH_OP,
        PH_DEV,
        PH_REG,
        PH_TA1,
        PH_TA2,
        PH_DATA
    } phase_t;

    typedef struct packed {
        logic               ext;
        logic               hit;
        logic               live;
        logic [BYTE_W-1:0]  index;
    } sel_t;

    function automatic logic ext_sel(input logic [FIELD_W-1:0] dev);
        return dev[2] & dev[1];
    endfunction

    function automatic logic [BYTE_W-1:0] ext_index(input logic [FIELD_W-1:0] dev,
                                                    input logic [FIELD_W-1:0] ra);
        return {dev[4:3], dev[0], ra};
    endfunction

    function automatic logic std_reg_ok(input logic [FIELD_W-1:0] ra);
        return (ra <= 5'd5) || (ra == 5'd29) || (ra == 5'd31);
    endfunction

endpackage

// File: rtl/mdio_pre_det.sv
`timescale 1ns/1ps
module mdio_pre_det #(
    parameter int PRE_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_i,
    input  logic hold,
    output logic pre_ok
);
    localparam int CW = $clog2(PRE_LEN + 1);

    logic [CW-1:0] run;

    assign pre_ok = (run == CW'(PRE_LEN));

    always_ff @(posedge clk) begin
        if (rst || hold || !bit_i) begin
            run <= '0;
        end else if (!pre_ok) begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_addr_dec.sv
`timescale 1ns/1ps
module mdio_addr_dec
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PHY_BASE  = 1,
    parameter int PORT_W    = 3
) (
    input  logic [FIELD_W-1:0] dev,
    input  logic [FIELD_W-1:0] ra,
    output sel_t               sel,
    output logic [PORT_W-1:0]  port
);
    localparam int RW = FIELD_W + 1;
    localparam logic [RW-1:0] BASE_W = RW'(PHY_BASE);
    localparam logic [RW-1:0] NP_W   = RW'(NUM_PORTS);

    logic [RW-1:0] rel;
    logic          std_hit;
    logic          is_ext;

    assign rel     = {1'b0, dev} - BASE_W;
    assign std_hit = ({1'b0, dev} >= BASE_W) && (rel < NP_W);
    assign is_ext  = ext_sel(dev);

    always_comb begin
        sel.ext   = is_ext;
        sel.hit   = is_ext || std_hit;
        sel.live  = is_ext || std_reg_ok(ra);
        sel.index = is_ext ? ext_index(dev, ra) : {3'b000, ra};
        port      = rel[PORT_W-1:0];
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
`timescale 1ns/1ps
module mdio_frame_fsm
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PHY_BASE  = 1,
    parameter int PORT_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bit_i,
    input  logic               pre_ok,
    output phase_t             phase,
    output logic               rd_mode,
    output logic               tx_msb,
    output logic               acc_rd,
    output logic               acc_wr,
    output logic               acc_ext,
    output logic [PORT_W-1:0]  acc_port,
    output logic [BYTE_W-1:0]  acc_index,
    output logic [DATA_W-1:0]  acc_wdata,
    input  logic [DATA_W-1:0]  acc_rdata
);
    localparam logic [CNT_W-1:0] LAST_OP    = CNT_W'(1);
    localparam logic [CNT_W-1:0] LAST_FIELD = CNT_W'(FIELD_W - 1);
    localparam logic [CNT_W-1:0] LAST_DATA  = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]   cnt;
    logic [1:0]         op_q;
    logic [1:0]         op_nxt;
    logic [FIELD_W-1:0] dev_q;
    logic [FIELD_W-1:0] ra_q;
    logic [FIELD_W-1:0] ra_nxt;
    logic [DATA_W-1:0]  shreg;
    logic [DATA_W-1:0]  sh_nxt;
    logic               live_q;
    sel_t               sel;
    logic [PORT_W-1:0]  sel_port;

    assign op_nxt = {op_q[0], bit_i};
    assign ra_nxt = {ra_q[FIELD_W-2:0], bit_i};
    assign sh_nxt = {shreg[DATA_W-2:0], bit_i};
    assign tx_msb = shreg[DATA_W-1];

    mdio_addr_dec #(
        .NUM_PORTS (NUM_PORTS),
        .PHY_BASE  (PHY_BASE),
        .PORT_W    (PORT_W)
    ) u_dec (
        .dev  (dev_q),
        .ra   (ra_nxt),
        .sel  (sel),
        .port (sel_port)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_HUNT;
            cnt       <= '0;
            op_q      <= '0;
            dev_q     <= '0;
            ra_q      <= '0;
            shreg     <= '0;
            rd_mode   <= 1'b0;
            live_q    <= 1'b0;
            acc_rd    <= 1'b0;
            acc_wr    <= 1'b0;
            acc_ext   <= 1'b0;
            acc_port  <= '0;
            acc_index <= '0;
            acc_wdata <= '0;
        end else begin
            acc_rd <= 1'b0;
            acc_wr <= 1'b0;
            unique case (phase)
                PH_HUNT: begin
                    if (pre_ok && !bit_i) phase <= PH_SOF;
                end
                PH_SOF: begin
                    cnt   <= '0;
                    phase <= bit_i ? PH_OP : PH_HUNT;
                end
                PH_OP: begin
                    op_q <= op_nxt;
                    if (cnt == LAST_OP) begin
                        cnt   <= '0;
                        phase <= (op_nxt == OP_RD || op_nxt == OP_WR) ? PH_DEV : PH_HUNT;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_DEV: begin
                    dev_q <= {dev_q[FIELD_W-2:0], bit_i};
                    if (cnt == LAST_FIELD) begin
                        cnt   <= '0;
                        phase <= PH_REG;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_REG: begin
                    ra_q <= ra_nxt;
                    if (cnt == LAST_FIELD) begin
                        cnt <= '0;
                        if (sel.hit) begin
                            phase     <= PH_TA1;
                            rd_mode   <= (op_q == OP_RD);
                            acc_rd    <= (op_q == OP_RD) && sel.live;
                            live_q    <= sel.live;
                            acc_ext   <= sel.ext;
                            acc_port  <= sel_port;
                            acc_index <= sel.index;
                        end else begin
                            phase <= PH_HUNT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_TA1: begin
                    phase <= PH_TA2;
                    if (rd_mode) begin
                        if (!live_q)      shreg <= '0;
                        else if (acc_ext) shreg <= {{(DATA_W-BYTE_W){1'b0}}, acc_rdata[BYTE_W-1:0]};
                        else              shreg <= acc_rdata;
                    end
                end
                PH_TA2: begin
                    phase <= PH_DATA;
                    cnt   <= '0;
                end
                PH_DATA: begin
                    shreg <= sh_nxt;
                    if (cnt == LAST_DATA) begin
                        phase   <= PH_HUNT;
                        cnt     <= '0;
                        rd_mode <= 1'b0;
                        if (!rd_mode && live_q) begin
                            acc_wr    <= 1'b1;
                            acc_wdata <= acc_ext ? {{(DATA_W-BYTE_W){1'b0}}, sh_nxt[BYTE_W-1:0]}
                                                 : sh_nxt;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/mdio_tx_drv.sv
`timescale 1ns/1ps
module mdio_tx_drv
    import mdio_tgt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  phase_t phase,
    input  logic   rd_mode,
    input  logic   tx_msb,
    output logic   mdio_o,
    output logic   mdio_oe
);
    always_ff @(negedge clk) begin
        if (rst) begin
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
        end else begin
            mdio_oe <= rd_mode && (phase == PH_TA2 || phase == PH_DATA);
            mdio_o  <= (phase == PH_DATA) ? tx_msb : 1'b0;
        end
    end
endmodule

// File: rtl/mdio_mgmt_target.sv
`timescale 1ns/1ps
module mdio_mgmt_target
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PHY_BASE  = 1,
    parameter int PORT_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic              acc_rd,
    output logic              acc_wr,
    output logic              acc_ext,
    output logic [PORT_W-1:0] acc_port,
    output logic [7:0]        acc_index,
    output logic [15:0]       acc_wdata,
    input  logic [15:0]       acc_rdata
);
    phase_t phase;
    logic   rd_mode;
    logic   tx_msb;
    logic   pre_ok;
    logic   busy;

    assign busy = (phase != PH_HUNT);

    mdio_pre_det #(
        .PRE_LEN (PRE_LEN)
    ) u_pre (
        .clk    (clk),
        .rst    (rst),
        .bit_i  (mdio_i),
        .hold   (busy),
        .pre_ok (pre_ok)
    );

    mdio_frame_fsm #(
        .NUM_PORTS (NUM_PORTS),
        .PHY_BASE  (PHY_BASE),
        .PORT_W    (PORT_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (mdio_i),
        .pre_ok    (pre_ok),
        .phase     (phase),
        .rd_mode   (rd_mode),
        .tx_msb    (tx_msb),
        .acc_rd    (acc_rd),
        .acc_wr    (acc_wr),
        .acc_ext   (acc_ext),
        .acc_port  (acc_port),
        .acc_index (acc_index),
        .acc_wdata (acc_wdata),
        .acc_rdata (acc_rdata)
    );

    mdio_tx_drv u_tx (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .rd_mode (rd_mode),
        .tx_msb  (tx_msb),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe)
    );
endmodule

// File: rtl/mdio_mgmt_target_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_target_chk
    import mdio_tgt_pkg::*;
#(
    parameter int NUM_PORTS = 5,
    parameter int PORT_W    = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              mdio_oe,
    input logic              acc_rd,
    input logic              acc_wr,
    input logic              acc_ext,
    input logic [PORT_W-1:0] acc_port,
    input logic [7:0]        acc_index,
    input logic [15:0]       acc_wdata
);
    localparam logic [PORT_W:0] NP_W = (PORT_W+1)'(NUM_PORTS);

    a_r12_reset_quiet: assert property (@(posedge clk)
        rst |=> (!acc_rd && !acc_wr));

    a_r10_rd_one_cycle: assert property (@(posedge clk) disable iff (rst)
        acc_rd |=> !acc_rd);

    a_r9_wr_one_cycle: assert property (@(posedge clk) disable iff (rst)
        acc_wr |=> !acc_wr);

    a_r2_rd_wr_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(acc_rd && acc_wr));

    a_r3_ta1_released: assert property (@(posedge clk) disable iff (rst)
        acc_rd |-> !mdio_oe);

    a_r3_no_drive_on_write: assert property (@(posedge clk) disable iff (rst)
        acc_wr |-> !mdio_oe);

    a_r6_ext_upper_zero: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_ext) |-> (acc_wdata[15:8] == 8'h00));

    a_r8_std_live_reg: assert property (@(posedge clk) disable iff (rst)
        ((acc_wr || acc_rd) && !acc_ext) |-> std_reg_ok(acc_index[4:0]));

    a_r7_port_range: assert property (@(posedge clk) disable iff (rst)
        ((acc_wr || acc_rd) && !acc_ext) |-> ({1'b0, acc_port} < NP_W));
endmodule

bind mdio_mgmt_target mdio_mgmt_target_chk #(
    .NUM_PORTS (NUM_PORTS),
    .PORT_W    (PORT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mdio_oe   (mdio_oe),
    .acc_rd    (acc_rd),
    .acc_wr    (acc_wr),
    .acc_ext   (acc_ext),
    .acc_port  (acc_port),
    .acc_index (acc_index),
    .acc_wdata (acc_wdata)
);

// File: tb/tb_mdio_mgmt_target.sv
`timescale 1ns/1ps
module tb_mdio_mgmt_target;
    localparam int NP = 5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mdio_i;
    logic        mdio_o;
    logic        mdio_oe;
    logic        acc_rd;
    logic        acc_wr;
    logic        acc_ext;
    logic [2:0]  acc_port;
    logic [7:0]  acc_index;
    logic [15:0] acc_wdata;
    logic [15:0] acc_rdata;

    logic m_drv = 1'b0;
    logic m_val = 1'b1;
    logic s_oe;
    logic s_line;
    logic mem_init = 1'b1;

    int n_chk = 0;
    int n_bad = 0;
    int wr_seen = 0;
    int rd_seen = 0;
    logic [15:0] last_wd = '0;

    logic [15:0] f_rd;
    int          f_oe_n;
    logic        f_ta1_oe;
    logic        f_ta2_ok;

    logic [15:0] std_mem [NP][32];
    logic [7:0]  ext_mem [256];
    logic [15:0] sh_std  [NP][32];
    logic [7:0]  sh_ext  [256];

    always #2 clk = ~clk;

    assign mdio_i = mdio_oe ? mdio_o : (m_drv ? m_val : 1'b1);
    assign acc_rdata = acc_ext ? {8'hA5, ext_mem[acc_index]}
                               : std_mem[(acc_port < 3'd5) ? acc_port : 3'd0][acc_index[4:0]];

    mdio_mgmt_target #(.NUM_PORTS(NP), .PHY_BASE(1)) dut (
        .clk(clk), .rst(rst), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .acc_rd(acc_rd), .acc_wr(acc_wr), .acc_ext(acc_ext), .acc_port(acc_port),
        .acc_index(acc_index), .acc_wdata(acc_wdata), .acc_rdata(acc_rdata)
    );

    function automatic logic [15:0] init_std(input int p, input int r);
        return 16'(p * 4099 + r * 257 + 1);
    endfunction

    function automatic logic [7:0] init_ext(input int i);
        return 8'(i * 7 + 3);
    endfunction

    always @(posedge clk) begin
        if (mem_init) begin
            for (int p = 0; p < NP; p++)
                for (int r = 0; r < 32; r++) std_mem[p][r] <= init_std(p, r);
            for (int i = 0; i < 256; i++) ext_mem[i] <= init_ext(i);
        end else if (acc_wr) begin
            if (acc_ext) ext_mem[acc_index] <= acc_wdata[7:0];
            else if (acc_port < 3'd5) std_mem[acc_port][acc_index[4:0]] <= acc_wdata;
        end
        if (acc_wr) begin
            wr_seen <= wr_seen + 1;
            last_wd <= acc_wdata;
        end
        if (acc_rd) rd_seen <= rd_seen + 1;
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit b_std_ok(input logic [4:0] r);
        return (r <= 5'd5) || (r == 5'd29) || (r == 5'd31);
    endfunction

    task automatic bitx(input logic v, input logic rel);
        @(negedge clk);
        m_drv = !rel;
        m_val = v;
        #1;
        s_oe   = mdio_oe;
        s_line = mdio_i;
        if (s_oe) f_oe_n++;
    endtask

    task automatic frame(input int pre, input bit lead0, input logic [1:0] sof, input logic [1:0] op,
                         input logic [4:0] dev, input logic [4:0] ra, input logic [15:0] wd, input int cut);
        bit rd_op;
        rd_op    = (op == 2'b10);
        f_oe_n   = 0;
        f_rd     = '0;
        f_ta1_oe = 1'b0;
        f_ta2_ok = 1'b0;
        if (lead0) bitx(1'b0, 1'b0);
        for (int i = 0; i < pre; i++) bitx(1'b1, 1'b0);
        bitx(sof[1], 1'b0);
        bitx(sof[0], 1'b0);
        bitx(op[1], 1'b0);
        bitx(op[0], 1'b0);
        for (int i = 4; i >= 0; i--) bitx(dev[i], 1'b0);
        for (int i = 4; i >= 0; i--) bitx(ra[i], 1'b0);
        if (rd_op) begin
            bitx(1'b1, 1'b1);
            f_ta1_oe = s_oe;
            bitx(1'b1, 1'b1);
            f_ta2_ok = s_oe && !s_line;
        end else begin
            bitx(1'b1, 1'b0);
            bitx(1'b0, 1'b0);
        end
        for (int i = 15; i >= 0; i--) begin
            if (cut == 15 - i) begin
                rst = 1'b1;
                repeat (2) @(negedge clk);
                #1;
                rst   = 1'b0;
                m_drv = 1'b0;
                return;
            end
            if (rd_op) begin
                bitx(1'b1, 1'b1);
                f_rd = {f_rd[14:0], s_line};
            end else begin
                bitx(wd[i], 1'b0);
            end
        end
        bitx(1'b1, 1'b1);
        bitx(1'b1, 1'b1);
    endtask

    function automatic bit dev_ext(input logic [4:0] d);
        return d[2] && d[1];
    endfunction

    function automatic bit dev_hit(input logic [4:0] d);
        return dev_ext(d) || (d >= 5'd1 && d <= 5'd5);
    endfunction

    // Write then read one address; expectations follow R4, R5, R7, R8.
    task automatic wr_rd(input logic [4:0] d, input logic [4:0] r, input logic [15:0] wd);
        int w0;
        int r0;
        bit ext;
        bit hit;
        bit live;
        logic [7:0] idx;
        logic [15:0] exp_rd;
        ext  = dev_ext(d);
        hit  = dev_hit(d);
        live = ext || b_std_ok(r);
        idx  = {d[4:3], d[0], r};
        w0 = wr_seen;
        frame(32, 1'b1, 2'b01, 2'b01, d, r, wd, -1);
        chk((wr_seen - w0) == ((hit && live) ? 1 : 0), ext ? "R4 ext write strobe" : "R7/R8 std write strobe",
            32'(wr_seen - w0), 32'((hit && live) ? 1 : 0));
        chk(f_oe_n == 0, "R3 no drive during write", 32'(f_oe_n), 0);
        if (ext) begin
            sh_ext[idx] = wd[7:0];
            chk(last_wd[15:8] == 8'h00, "R6 ext write upper byte", 32'(last_wd), 32'({8'h00, wd[7:0]}));
        end else if (hit && live) begin
            sh_std[d - 5'd1][r] = wd;
        end
        r0 = rd_seen;
        frame(32, 1'b1, 2'b01, 2'b10, d, r, 16'h0000, -1);
        chk(f_oe_n == (hit ? 17 : 0), "R3/R7 read drive length", 32'(f_oe_n), 32'(hit ? 17 : 0));
        chk((rd_seen - r0) == ((hit && live) ? 1 : 0), "R10 read strobe count",
            32'(rd_seen - r0), 32'((hit && live) ? 1 : 0));
        if (hit) begin
            if (ext)       exp_rd = {8'h00, sh_ext[idx]};
            else if (live) exp_rd = sh_std[d - 5'd1][r];
            else           exp_rd = 16'h0000;
            chk(f_rd == exp_rd, ext ? "R5 ext read data" : "R8 std read data", 32'(f_rd), 32'(exp_rd));
            chk(!f_ta1_oe && f_ta2_ok, "R3 turnaround", 32'({f_ta1_oe, f_ta2_ok}), 32'b01);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=expired expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int w0;
        int rl [8];
        rl = '{0, 1, 5, 6, 28, 29, 30, 31};
        for (int p = 0; p < NP; p++)
            for (int r = 0; r < 32; r++) sh_std[p][r] = init_std(p, r);
        for (int i = 0; i < 256; i++) sh_ext[i] = init_ext(i);

        repeat (4) @(negedge clk);
        #1;
        chk(!mdio_oe && !acc_rd && !acc_wr, "R12 reset state", 32'({mdio_oe, acc_rd, acc_wr}), 0);
        rst = 1'b0;
        mem_init = 1'b0;

        // Standard and extended addressing over every device address
        for (int p = 0; p < 32; p++)
            for (int k = 0; k < 8; k++)
                wr_rd(5'(p), 5'(rl[k]), 16'((p * 1237 + rl[k] * 91 + 23) ^ 16'h5A00));

        // Full extended index space: R4, R5, R6
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            b = 8'(i);
            wr_rd({b[7:6], 2'b11, b[5]}, b[4:0], {8'hC3, b ^ 8'h5A});
        end

        // R1: 31 ones is too short
        w0 = wr_seen;
        frame(31, 1'b1, 2'b01, 2'b01, 5'd1, 5'd0, 16'hDEAD, -1);
        chk(wr_seen == w0, "R1 short preamble ignored", 32'(wr_seen - w0), 0);
        frame(31, 1'b1, 2'b01, 2'b10, 5'd1, 5'd0, 16'h0, -1);
        chk(f_oe_n == 0, "R1 short preamble no drive", 32'(f_oe_n), 0);
        // R1: bad start pattern
        w0 = wr_seen;
        frame(32, 1'b1, 2'b00, 2'b01, 5'd2, 5'd1, 16'hBEEF, -1);
        chk(wr_seen == w0, "R1 bad start ignored", 32'(wr_seen - w0), 0);

        // R2: invalid opcodes
        w0 = wr_seen;
        frame(32, 1'b1, 2'b01, 2'b00, 5'd2, 5'd1, 16'h1234, -1);
        frame(32, 1'b1, 2'b01, 2'b11, 5'd2, 5'd1, 16'h1234, -1);
        chk(wr_seen == w0, "R2 bad opcode no strobe", 32'(wr_seen - w0), 0);
        chk(f_oe_n == 0, "R2 bad opcode no drive", 32'(f_oe_n), 0);

        // R11: abort at opcode, then only 30 ones before a start
        for (int i = 0; i < 32; i++) bitx(1'b1, 1'b0);
        bitx(1'b0, 1'b0); bitx(1'b1, 1'b0); bitx(1'b1, 1'b0); bitx(1'b1, 1'b0);
        w0 = wr_seen;
        frame(30, 1'b0, 2'b01, 2'b01, 5'd1, 5'd0, 16'h7777, -1);
        chk(wr_seen == w0, "R11 fresh preamble required", 32'(wr_seen - w0), 0);
        frame(32, 1'b1, 2'b01, 2'b10, 5'd1, 5'd0, 16'h0, -1);
        chk(f_rd == sh_std[0][0], "R11 register unchanged", 32'(f_rd), 32'(sh_std[0][0]));

        // R9: write cut short by reset
        w0 = wr_seen;
        frame(32, 1'b1, 2'b01, 2'b01, 5'd3, 5'd2, 16'h4242, 8);
        repeat (3) @(negedge clk);
        chk(wr_seen == w0, "R9 aborted write no strobe", 32'(wr_seen - w0), 0);
        frame(32, 1'b1, 2'b01, 2'b10, 5'd3, 5'd2, 16'h0, -1);
        chk(f_rd == sh_std[2][2], "R9 register unchanged after abort", 32'(f_rd), 32'(sh_std[2][2]));
        wr_rd(5'd3, 5'd2, 16'h4242);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule